// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block records memory-management faults for a processor core. Each fault report arrives as a single-cycle pulse. The pulse carries a fault class, a priority, an access type, a fault type code and a virtual address. The block decides whether that report is latched into the fault status register, and whether its address is latched into the fault address register. It also marks repeated faults of the same class with an overwrite bit.

Software reads the two registers through a small read port. A status read returns the value held and clears it. An address read leaves the address register unchanged. A no-fault control bit lets software freeze both registers against new reports while it works.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, the status register and the address register both read as zero.
- R2: The status word packs the following fields: valid in bit 0, fault type in bits 3:1, access type in bits 5:4, class in bits 7:6, overwrite in bit 8, and the priority in bits 8+PRIO_W:9. A fault that arrives while the status is not valid is latched with overwrite 0.
- R3: While a valid fault is held, a new fault with a numerically lower priority leaves every status field unchanged.
- R4: A new fault with a priority equal to or higher than the held priority replaces the held fields.
- R5: A replacing fault sets overwrite to 1 when its class equals the held class. When the class differs, the new overwrite is 0.
- R6: The address register loads the fault address only when the status register also latches that fault, and only for a data access. Access codes with bit 1 set are instruction accesses and never load the address register.
- R7: rdSel=0 selects status and rdSel=1 selects address. rdData shows the current value combinationally. A status read clears the whole status word on the next edge. An address read changes nothing.
- R8: When a status read and a fault arrive in the same cycle, the fault is latched into the cleared status with overwrite 0, and it is not lost.
- R9: While noFault is 1, fault reports change neither register. Status reads still clear the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | One-cycle fault report strobe |
| faultClass | input | 2 | Fault class |
| faultPrio | input | PRIO_W | Fault priority, larger is higher |
| faultAccess | input | 2 | Access type; bit 1 set means instruction |
| faultType | input | 3 | Fault type code |
| faultAddr | input | ADDR_W | Virtual address of the faulting access |
| noFault | input | 1 | Suppress fault capture |
| rdEn | input | 1 | Register read strobe |
| rdSel | input | 1 | 0 = status, 1 = address |
| rdData | output | ADDR_W | Read data |

## Verification
A wrong held priority or a wrong held class shows up on the very next status read. It appears as a wrong field value or as a wrong overwrite bit. A wrong address-load decision appears on the next address read, and it persists there because reads never clear that register. The bench sweeps every pair of consecutive faults over class, priority and access kind. It then runs a long pseudo-random mix of reads, same-cycle read-and-fault cases and suppressed periods. Every read is compared in the cycle it occurs, so any divergence is seen within one cycle of the next read.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam logic RD_STATUS = 1'b0;
  localparam logic RD_ADDR   = 1'b1;

  typedef struct packed {
    logic clrStat;
    logic loadStat;
    logic loadAddr;
    logic ovwNew;
  } strobe_t;
endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl #(
  parameter int PRIO_W = 2
) (
  input  logic              faultValid,
  input  logic [1:0]        faultClass,
  input  logic [PRIO_W-1:0] faultPrio,
  input  logic [1:0]        faultAccess,
  input  logic              noFault,
  input  logic              rdEn,
  input  logic              rdSel,
  input  logic              heldValid,
  input  logic [1:0]        heldClass,
  input  logic [PRIO_W-1:0] heldPrio,
  output mfc_pkg::strobe_t  strobes
);
  logic clrNow;
  logic effValid;
  logic wins;

  always_comb begin
    clrNow   = rdEn && (rdSel == mfc_pkg::RD_STATUS);
    // a status read this cycle empties the register before a new fault lands
    effValid = heldValid && !clrNow;
    wins     = faultValid && !noFault && (!effValid || (faultPrio >= heldPrio));
    strobes.clrStat  = clrNow;
    strobes.loadStat = wins;
    strobes.loadAddr = wins && !faultAccess[1];
    strobes.ovwNew   = effValid && (faultClass == heldClass);
  end
endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath #(
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 2,
  localparam int STAT_W = 9 + PRIO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mfc_pkg::strobe_t  strobes,
  input  logic [1:0]        faultClass,
  input  logic [PRIO_W-1:0] faultPrio,
  input  logic [1:0]        faultAccess,
  input  logic [2:0]        faultType,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              rdSel,
  output logic              heldValid,
  output logic [1:0]        heldClass,
  output logic [PRIO_W-1:0] heldPrio,
  output logic [STAT_W-1:0] statusWord,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] rdData
);
  logic              statV;
  logic [2:0]        statType;
  logic [1:0]        statAcc;
  logic [1:0]        statCls;
  logic              statOvw;
  logic [PRIO_W-1:0] statPrio;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statV    <= 1'b0;
      statType <= '0;
      statAcc  <= '0;
      statCls  <= '0;
      statOvw  <= 1'b0;
      statPrio <= '0;
      addrQ    <= '0;
    end else begin
      if (strobes.clrStat) begin
        statV    <= 1'b0;
        statType <= '0;
        statAcc  <= '0;
        statCls  <= '0;
        statOvw  <= 1'b0;
        statPrio <= '0;
      end
      if (strobes.loadStat) begin
        statV    <= 1'b1;
        statType <= faultType;
        statAcc  <= faultAccess;
        statCls  <= faultClass;
        statOvw  <= strobes.ovwNew;
        statPrio <= faultPrio;
      end
      if (strobes.loadAddr) addrQ <= faultAddr;
    end
  end

  assign heldValid  = statV;
  assign heldClass  = statCls;
  assign heldPrio   = statPrio;
  assign statusWord = {statPrio, statOvw, statCls, statAcc, statType, statV};

  always_comb begin
    if (rdSel == mfc_pkg::RD_ADDR) rdData = addrQ;
    else                           rdData = {{(ADDR_W-STAT_W){1'b0}}, statusWord};
  end

  // R5
  ovw_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[8] |-> statusWord[0]);
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [1:0]        faultClass,
  input  logic [PRIO_W-1:0] faultPrio,
  input  logic [1:0]        faultAccess,
  input  logic [2:0]        faultType,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              noFault,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [ADDR_W-1:0] rdData
);
  localparam int STAT_W = 9 + PRIO_W;

  mfc_pkg::strobe_t  strobes;
  logic              heldValid;
  logic [1:0]        heldClass;
  logic [PRIO_W-1:0] heldPrio;
  logic [STAT_W-1:0] statusWord;
  logic [ADDR_W-1:0] addrQ;

  mfc_ctrl #(.PRIO_W(PRIO_W)) ctrl (
    .faultValid(faultValid), .faultClass(faultClass), .faultPrio(faultPrio),
    .faultAccess(faultAccess), .noFault(noFault), .rdEn(rdEn), .rdSel(rdSel),
    .heldValid(heldValid), .heldClass(heldClass), .heldPrio(heldPrio),
    .strobes(strobes)
  );

  mfc_datapath #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .faultClass(faultClass),
    .faultPrio(faultPrio), .faultAccess(faultAccess), .faultType(faultType),
    .faultAddr(faultAddr), .rdSel(rdSel), .heldValid(heldValid),
    .heldClass(heldClass), .heldPrio(heldPrio), .statusWord(statusWord),
    .addrQ(addrQ), .rdData(rdData)
  );

  logic statRead;
  assign statRead = rdEn && (rdSel == 1'b0);

  // R3
  low_prio_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[0] && !statRead && faultValid &&
     (faultPrio < statusWord[STAT_W-1:9])) |=> $stable(statusWord));

  // R6
  instr_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(faultValid && !faultAccess[1]) |=> $stable(addrQ));

  // R9
  nofault_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (noFault && !statRead) |=> ($stable(statusWord) && $stable(addrQ)));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !faultValid) |=> (statusWord == '0));

  // R8
  read_and_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && faultValid && !noFault) |=> (statusWord[0] && !statusWord[8]));
endmodule

// File: tb/tb_mmu_fault_capture.sv
module tb_mmu_fault_capture;
  localparam int ADDR_W = 32;
  localparam int PRIO_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              faultValid = 1'b0;
  logic [1:0]        faultClass = '0;
  logic [PRIO_W-1:0] faultPrio = '0;
  logic [1:0]        faultAccess = '0;
  logic [2:0]        faultType = '0;
  logic [ADDR_W-1:0] faultAddr = '0;
  logic              noFault = 1'b0;
  logic              rdEn = 1'b0;
  logic              rdSel = 1'b0;
  logic [ADDR_W-1:0] rdData;

  int errors = 0;
  int checks = 0;

  // bench model of the two registers
  logic        mV;
  logic [2:0]  mType;
  logic [1:0]  mAcc;
  logic [1:0]  mCls;
  logic        mOvw;
  logic [1:0]  mPrio;
  logic [31:0] mAddr;

  always #4 clk = ~clk;

  mmu_fault_capture #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) dut (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultClass(faultClass),
    .faultPrio(faultPrio), .faultAccess(faultAccess), .faultType(faultType),
    .faultAddr(faultAddr), .noFault(noFault), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData)
  );

  initial begin
    #(8 * 200000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] packStat();
    return {21'd0, mPrio, mOvw, mCls, mAcc, mType, mV};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, sample reads before the edge, update model
  task automatic step(input logic fv, input logic [1:0] cls, input logic [1:0] pr,
                      input logic [1:0] acc, input logic [2:0] typ, input logic [31:0] ad,
                      input logic nf, input logic re, input logic rs, input string tag);
    logic clr, effV, wins;
    @(negedge clk);
    faultValid = fv; faultClass = cls; faultPrio = pr; faultAccess = acc;
    faultType = typ; faultAddr = ad; noFault = nf; rdEn = re; rdSel = rs;
    #1;
    if (re) check(tag, rdData, rs ? mAddr : packStat());
    clr  = re && !rs;
    effV = mV && !clr;
    wins = fv && !nf && (!effV || pr >= mPrio);
    if (clr) begin
      mV = 0; mType = 0; mAcc = 0; mCls = 0; mOvw = 0; mPrio = 0;
    end
    if (wins) begin
      mOvw = effV && (cls == mCls);
      mV = 1; mType = typ; mAcc = acc; mCls = cls; mPrio = pr;
      if (!acc[1]) mAddr = ad;
    end
  endtask

  task automatic idle(input logic re, input logic rs, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, re, rs, tag);
  endtask

  initial begin
    logic [31:0] seed;
    mV = 0; mType = 0; mAcc = 0; mCls = 0; mOvw = 0; mPrio = 0; mAddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    idle(1, 1, "R1 address");
    idle(1, 0, "R1 status");

    // R2 field layout on a single data fault
    step(1, 2'd2, 2'd1, 2'd1, 3'd5, 32'hCAFE_0010, 0, 0, 0, "");
    idle(1, 0, "R2 layout");

    // exhaustive sweep of two consecutive faults
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        logic [1:0] c1, p1, c2, p2, ac1, ac2;
        string tg;
        c1 = a[1:0]; p1 = a[3:2]; ac1 = a[4] ? 2'b10 : 2'b01;
        c2 = b[1:0]; p2 = b[3:2]; ac2 = b[4] ? 2'b11 : 2'b00;
        idle(1, 0, "R7 clear");
        step(1, c1, p1, ac1, 3'(a), 32'h1000_0000 + 32'(a), 0, 0, 0, "");
        step(1, c2, p2, ac2, 3'(b + 1), 32'h2000_0000 + 32'(b), 0, 0, 0, "");
        if (p2 < p1)       tg = "R3 lower priority kept";
        else if (c2 == c1) tg = "R5 overwrite same class";
        else               tg = "R4 replace";
        idle(1, 0, tg);
        idle(1, 1, "R6 address");
      end
    end

    // R8 read and fault together
    step(1, 2'd1, 2'd3, 2'd0, 3'd2, 32'hAAAA_0000, 0, 0, 0, "");
    step(1, 2'd1, 2'd0, 2'd0, 3'd3, 32'hBBBB_0000, 0, 1, 0, "R8 read value");
    idle(1, 0, "R8 new fault kept");

    // R9 suppression
    step(1, 2'd3, 2'd3, 2'd0, 3'd7, 32'hDEAD_0000, 1, 0, 0, "");
    idle(1, 0, "R9 status frozen");
    idle(1, 1, "R9 address frozen");

    // pseudo-random mix
    seed = 32'h1234_5678;
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] r;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      r = seed;
      step(r[0], r[2:1], r[4:3], r[6:5], r[9:7], {r[31:16], 16'(i)}, r[10] & r[11],
           r[12] | r[13], r[14], r[14] ? "R6 random address" : "R7 R8 random status");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule